// File: doc/BRIEF.md
# Semaphore-Guarded Receive Message Object

This block holds a single received CAN message object: an 11-bit identifier, a 4-bit data length code and eight data bytes. Two agents share it. A filter-side writer fills it through a start / byte-write / finish port. A CPU fetches it as three 32-bit words through a register port. A two-bit semaphore sits between them, and neither side ever waits for the other.

The writer opens an update with `wr_start`. This captures the identifier and length and moves the semaphore to busy (01). While busy, the writer stores bytes by index. It then closes the update with `wr_done`, which moves the semaphore to ready (11). To consume the object, the CPU writes 00 to the semaphore, reads the data words, and reads the semaphore again. If the value is still 00, the copy is consistent. Any other value means the writer started over during the read, and the CPU must read again.

The semaphore is a three-state machine (type `sem_e`). The states are SEM_IDLE (00, consumed or never written), SEM_BUSY (01, writer updating) and SEM_READY (11, complete). The transitions are:
- START: any state to SEM_BUSY on `wr_start`.
- FINISH: SEM_BUSY to SEM_READY on `wr_done`.
- CLAIM: SEM_READY to SEM_IDLE on a CPU write of 00.
- HOLD: every other case keeps the current state.

Top module: `msgobj_sem_buf`

## Requirements
- R1: After reset the semaphore reads 00 and all four readable words read zero.
- R2: `wr_start` sets the semaphore to 01 on the next clock edge from any state, and captures `wr_id` and `wr_dlc` at that edge. It takes priority over `wr_done` and over a CPU write in the same cycle.
- R3: A byte write (`wr_byte_en`) accepted in the busy state or in a start cycle stores `wr_byte_data` at index `wr_byte_idx`. Byte n appears in word 1 (n<4) or word 2 (n>=4), at bits [8*(n%4)+7 : 8*(n%4)].
- R4: `wr_done` while the semaphore is 01, with no start in the same cycle, sets the semaphore to 11 on the next edge. A byte written in that same cycle is stored.
- R5: A CPU semaphore write of 00 while the semaphore is 11, with no start in the same cycle, sets it to 00 on the next edge.
- R6: A CPU semaphore write of 01, 10 or 11 has no effect on the semaphore.
- R7: A CPU semaphore write of 00 while the semaphore is 01 is ignored, so the semaphore stays 01 unless `wr_done` moves it to 11.
- R8: Byte writes and `wr_done` are ignored while the semaphore is 00 or 11 and no start is applied. Stored bytes and the semaphore stay unchanged.
- R9: The semaphore never takes the value 10.
- R10: CPU address 0 returns the identifier in bits [10:0], the data length code in bits [19:16] and the semaphore in bits [25:24], with all other bits zero. Address 3 returns zero.
- R11: If a new update starts after the CPU has cleared the semaphore, the CPU's closing semaphore read is non-zero (01 while the update is in progress, 11 after it finishes). The next clear-and-read then returns the new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Writer opens an update; captures identifier and length |
| wr_id | input | 11 | Identifier captured on start |
| wr_dlc | input | 4 | Data length code captured on start |
| wr_byte_en | input | 1 | Writer byte store strobe |
| wr_byte_idx | input | 3 | Index of the data byte being stored |
| wr_byte_data | input | 8 | Data byte value |
| wr_done | input | 1 | Writer closes the update |
| cpu_rd_addr | input | 2 | CPU word address (0 header, 1 bytes 0-3, 2 bytes 4-7, 3 zero) |
| cpu_rd_data | output | 32 | Word selected by `cpu_rd_addr`, combinational |
| cpu_sem_we | input | 1 | CPU semaphore write strobe |
| cpu_sem_wdata | input | 2 | Value written to the semaphore (only 00 is acted on) |

## Verification
The state machine is swept over every combination of starting state, CPU write value, `wr_start` and `wr_done`. This separates the priority order of START over FINISH and CLAIM, and shows that only 00 claims an object and only from the ready state. Data paths are filled with several arithmetic byte patterns and with extreme identifier and length values, including all-ones. These patterns expose lane swaps, index decoding faults and field misplacement in the header word. A scripted interleaving of CPU claim, new writer update and re-read shows that a torn read is always visible in the closing semaphore value.

// File: rtl/msgobj_pkg.sv
package msgobj_pkg;
    localparam int ID_W    = 11;
    localparam int LEN_W   = 4;
    localparam int N_BYTES = 8;
    localparam int WORD_W  = 32;
    localparam int IDX_W   = $clog2(N_BYTES);
    localparam int DATA_W  = N_BYTES * 8;
    localparam int N_DWORD = N_BYTES / 4;
    localparam int ADDR_W  = 2;

    // field positions inside header word
    localparam int HDR_LEN_LSB = 16;
    localparam int HDR_SEM_LSB = 24;

    typedef enum logic [1:0] {
        SEM_IDLE  = 2'b00,
        SEM_BUSY  = 2'b01,
        SEM_READY = 2'b11
    } sem_e;
endpackage

// File: rtl/msgobj_sem_fsm.sv
module msgobj_sem_fsm
    import msgobj_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       done_i,
    input  logic       cpu_we_i,
    input  logic [1:0] cpu_wdata_i,
    output sem_e       sem_o,
    output logic       accept_o
);
    sem_e state_q;
    sem_e state_d;
    logic claim;

    assign claim = cpu_we_i && (cpu_wdata_i == 2'b00);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEM_IDLE;
        else        state_q <= state_d;
    end

    // transitions: START beats FINISH and CLAIM
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = SEM_BUSY;
        end else begin
            unique case (state_q)
                SEM_IDLE:  state_d = SEM_IDLE;
                SEM_BUSY:  if (done_i) state_d = SEM_READY;
                SEM_READY: if (claim)  state_d = SEM_IDLE;
                default:   state_d = SEM_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sem_o    = state_q;
        accept_o = start_i || (state_q == SEM_BUSY);
    end
endmodule

// File: rtl/msgobj_store.sv
module msgobj_store
    import msgobj_pkg::*;
#(
    parameter int NB = N_BYTES,
    localparam int IW = $clog2(NB),
    localparam int DW = NB * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ID_W-1:0]  id_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             accept_i,
    input  logic             byte_en_i,
    input  logic [IW-1:0]    byte_idx_i,
    input  logic [7:0]       byte_data_i,
    output logic [ID_W-1:0]  id_o,
    output logic [LEN_W-1:0] len_o,
    output logic [DW-1:0]    data_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_o  <= '0;
            len_o <= '0;
        end else if (start_i) begin
            id_o  <= id_i;
            len_o <= len_i;
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                data_o[b*8 +: 8] <= '0;
            else if (accept_i && byte_en_i && (byte_idx_i == IW'(b)))
                data_o[b*8 +: 8] <= byte_data_i;
        end
    end
endmodule

// File: rtl/msgobj_rd_mux.sv
module msgobj_rd_mux
    import msgobj_pkg::*;
#(
    parameter int NB = N_BYTES,
    localparam int DW = NB * 8,
    localparam int NW = NB / 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic [LEN_W-1:0]  len_i,
    input  sem_e              sem_i,
    input  logic [DW-1:0]     data_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] hdr;

    always_comb begin
        hdr = '0;
        hdr[ID_W-1:0]                       = id_i;
        hdr[HDR_LEN_LSB +: LEN_W]           = len_i;
        hdr[HDR_SEM_LSB +: 2]               = sem_i;
    end

    always_comb begin
        word_o = '0;
        if (addr_i == '0) word_o = hdr;
        for (int k = 0; k < NW; k++) begin
            if (addr_i == ADDR_W'(k + 1)) word_o = data_i[k*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/msgobj_sem_buf.sv
module msgobj_sem_buf
    import msgobj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [LEN_W-1:0]  wr_dlc,
    input  logic              wr_byte_en,
    input  logic [IDX_W-1:0]  wr_byte_idx,
    input  logic [7:0]        wr_byte_data,
    input  logic              wr_done,
    input  logic [ADDR_W-1:0] cpu_rd_addr,
    output logic [WORD_W-1:0] cpu_rd_data,
    input  logic              cpu_sem_we,
    input  logic [1:0]        cpu_sem_wdata
);
    sem_e              sem_w;
    logic              accept_w;
    logic [ID_W-1:0]   id_w;
    logic [LEN_W-1:0]  len_w;
    logic [DATA_W-1:0] data_w;

    msgobj_sem_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (wr_start),
        .done_i      (wr_done),
        .cpu_we_i    (cpu_sem_we),
        .cpu_wdata_i (cpu_sem_wdata),
        .sem_o       (sem_w),
        .accept_o    (accept_w)
    );

    msgobj_store #(.NB(N_BYTES)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (wr_start),
        .id_i        (wr_id),
        .len_i       (wr_dlc),
        .accept_i    (accept_w),
        .byte_en_i   (wr_byte_en),
        .byte_idx_i  (wr_byte_idx),
        .byte_data_i (wr_byte_data),
        .id_o        (id_w),
        .len_o       (len_w),
        .data_o      (data_w)
    );

    msgobj_rd_mux #(.NB(N_BYTES)) u_mux (
        .addr_i (cpu_rd_addr),
        .id_i   (id_w),
        .len_i  (len_w),
        .sem_i  (sem_w),
        .data_i (data_w),
        .word_o (cpu_rd_data)
    );
endmodule

// File: rtl/msgobj_sem_sva.sv
module msgobj_sem_sva
    import msgobj_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_start,
    input logic              wr_done,
    input logic              wr_byte_en,
    input logic              cpu_sem_we,
    input logic [1:0]        cpu_sem_wdata,
    input logic [1:0]        sem,
    input logic [DATA_W-1:0] data
);
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> sem == 2'b01);

    assert_finish_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sem == 2'b01 && wr_done && !wr_start) |=> sem == 2'b11);

    assert_claim_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sem == 2'b11 && cpu_sem_we && cpu_sem_wdata == 2'b00 && !wr_start) |=> sem == 2'b00);

    assert_nonzero_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sem_we && cpu_sem_wdata != 2'b00 && !wr_start && !(sem == 2'b01 && wr_done))
        |=> $stable(sem));

    assert_clear_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sem == 2'b01 && cpu_sem_we && !wr_start && !wr_done) |=> sem == 2'b01);

    assert_bytes_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sem != 2'b01 && !wr_start && wr_byte_en) |=> $stable(data));

    assert_no_code_10_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sem != 2'b10);
endmodule

bind msgobj_sem_buf msgobj_sem_sva u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_start      (wr_start),
    .wr_done       (wr_done),
    .wr_byte_en    (wr_byte_en),
    .cpu_sem_we    (cpu_sem_we),
    .cpu_sem_wdata (cpu_sem_wdata),
    .sem           (sem_w),
    .data          (data_w)
);

// File: tb/msgobj_sem_buf_bench.sv
module msgobj_sem_buf_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_start, wr_byte_en, wr_done, cpu_sem_we;
    logic [10:0] wr_id;
    logic [3:0]  wr_dlc;
    logic [2:0]  wr_byte_idx;
    logic [7:0]  wr_byte_data;
    logic [1:0]  cpu_rd_addr, cpu_sem_wdata;
    logic [31:0] cpu_rd_data;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    msgobj_sem_buf u_msgobj_sem_buf (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_id(wr_id), .wr_dlc(wr_dlc),
        .wr_byte_en(wr_byte_en), .wr_byte_idx(wr_byte_idx), .wr_byte_data(wr_byte_data),
        .wr_done(wr_done), .cpu_rd_addr(cpu_rd_addr), .cpu_rd_data(cpu_rd_data),
        .cpu_sem_we(cpu_sem_we), .cpu_sem_wdata(cpu_sem_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet();
        wr_start = 0; wr_byte_en = 0; wr_done = 0; cpu_sem_we = 0;
        wr_id = '0; wr_dlc = '0; wr_byte_idx = '0; wr_byte_data = '0; cpu_sem_wdata = '0;
    endtask

    // inputs set at a negedge apply at the next posedge; results sampled at the following negedge
    task automatic tick();
        @(negedge clk);
        quiet();
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        cpu_rd_addr = a;
        #1;
        d = cpu_rd_data;
    endtask

    task automatic rd_sem(output logic [1:0] s);
        logic [31:0] w;
        rd(2'd0, w);
        s = w[25:24];
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 29 + i * 53 + 7) & 255);
    endfunction

    // full update: start, eight bytes, finish
    task automatic fill(input logic [10:0] id, input logic [3:0] dlc, input int seed);
        wr_start = 1; wr_id = id; wr_dlc = dlc;
        tick();
        for (int i = 0; i < 8; i++) begin
            wr_byte_en = 1; wr_byte_idx = 3'(i); wr_byte_data = pat(seed, i);
            if (i == 7) wr_done = 1;
            tick();
        end
    endtask

    task automatic go_state(input logic [1:0] s);
        wr_start = 1; wr_id = 11'h155; wr_dlc = 4'd3;
        tick();
        if (s != 2'b01) begin wr_done = 1; tick(); end
        if (s == 2'b00) begin cpu_sem_we = 1; cpu_sem_wdata = 2'b00; tick(); end
    endtask

    function automatic logic [1:0] exp_next(input logic [1:0] cur, input logic st,
                                            input logic dn, input logic we, input logic [1:0] wd);
        if (st) return 2'b01;
        if (cur == 2'b01) return dn ? 2'b11 : 2'b01;
        if (cur == 2'b11) return (we && wd == 2'b00) ? 2'b00 : 2'b11;
        return 2'b00;
    endfunction

    task automatic check_data(input string req, input int seed);
        logic [31:0] w1, w2;
        rd(2'd1, w1);
        rd(2'd2, w2);
        chk(req, w1, {pat(seed,3), pat(seed,2), pat(seed,1), pat(seed,0)});
        chk(req, w2, {pat(seed,7), pat(seed,6), pat(seed,5), pat(seed,4)});
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [1:0]  s;
        logic [1:0]  states [3];
        states[0] = 2'b00; states[1] = 2'b01; states[2] = 2'b11;
        quiet();
        cpu_rd_addr = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), w);
            chk("R1 reset word", w, 32'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R10: data patterns and header fields
        fill(11'h7FF, 4'hF, 1);
        rd(2'd0, w);
        chk("R10 header all-ones", w, 32'h030F_07FF);
        check_data("R3 pattern seed1", 1);
        fill(11'h000, 4'h0, 2);
        rd(2'd0, w);
        chk("R10 header zero id", w, 32'h0300_0000);
        check_data("R3 pattern seed2", 2);
        fill(11'h2A5, 4'h8, 3);
        rd(2'd0, w);
        chk("R4 R10 header mixed", w, 32'h0308_02A5);
        check_data("R3 pattern seed3", 3);
        rd(2'd3, w);
        chk("R10 address 3 zero", w, 32'h0);

        // R8: byte write and finish while ready are ignored
        wr_byte_en = 1; wr_byte_idx = 3'd0; wr_byte_data = 8'hEE; wr_done = 1;
        tick();
        check_data("R8 bytes locked when ready", 3);
        rd_sem(s);
        chk("R8 sem kept ready", 32'(s), 32'h3);
        // claim, then byte write and finish while idle are ignored
        cpu_sem_we = 1; cpu_sem_wdata = 2'b00;
        tick();
        wr_byte_en = 1; wr_byte_idx = 3'd5; wr_byte_data = 8'h11; wr_done = 1;
        tick();
        check_data("R8 bytes locked when idle", 3);
        rd_sem(s);
        chk("R8 sem kept idle", 32'(s), 32'h0);

        // R2 R4 R5 R6 R7 R9: exhaustive sweep of state x start x done x cpu write value
        for (int si = 0; si < 3; si++) begin
            for (int st = 0; st < 2; st++) begin
                for (int dn = 0; dn < 2; dn++) begin
                    for (int wd = 0; wd < 4; wd++) begin
                        go_state(states[si]);
                        rd_sem(s);
                        chk("R2 R4 R5 sweep entry", 32'(s), 32'(states[si]));
                        wr_start = st[0]; wr_id = 11'h0F0; wr_dlc = 4'd2;
                        wr_done = dn[0]; cpu_sem_we = 1; cpu_sem_wdata = 2'(wd);
                        tick();
                        rd_sem(s);
                        chk("R2 R4 R5 R6 R7 R9 sweep step", 32'(s),
                            32'(exp_next(states[si], st[0], dn[0], 1'b1, 2'(wd))));
                    end
                end
            end
        end

        // R2: start captures id/len and overrides a concurrent claim on ready
        go_state(2'b11);
        wr_start = 1; wr_id = 11'h3C3; wr_dlc = 4'd6; cpu_sem_we = 1; cpu_sem_wdata = 2'b00;
        tick();
        rd(2'd0, w);
        chk("R2 start beats claim", w, 32'h0106_03C3);

        // R11: torn read detected
        fill(11'h111, 4'd8, 4);
        cpu_sem_we = 1; cpu_sem_wdata = 2'b00;
        tick();
        check_data("R11 first read", 4);
        wr_start = 1; wr_id = 11'h222; wr_dlc = 4'd8;
        tick();
        wr_byte_en = 1; wr_byte_idx = 3'd0; wr_byte_data = 8'h99;
        tick();
        rd_sem(s);
        chk("R11 closing check during update", 32'(s), 32'h1);
        wr_done = 1;
        tick();
        rd_sem(s);
        chk("R11 closing check after update", 32'(s), 32'h3);
        cpu_sem_we = 1; cpu_sem_wdata = 2'b00;
        tick();
        rd(2'd1, w);
        chk("R11 reread byte0", {24'h0, w[7:0]}, 32'h99);
        rd(2'd0, w);
        chk("R11 reread header", w, 32'h0008_0222);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule